// File: doc/BRIEF.md
# Serially Loaded Four-Value Display Store

This block keeps four 8-bit values and shows any one of them on an 8-bit display port. A host fills the values over four wires: one serial data bit, a 2-bit register address and a shift strobe. On each clock where the strobe is high, only the addressed register moves right by one place and takes the serial bit into its most significant position. The other three registers are not touched. A full value therefore takes eight strobed clocks on one address, with the least significant bit sent first.

A separate 2-bit display select picks the register that drives the output. The path from the registers to the output has no flops, so a new select shows on the output in the same cycle. The host may change the address partway through a byte. Each register then keeps the bits it has received so far. The reset input is asynchronous and active low. It clears every register at once. Its release is synchronised inside the block, so shifting starts on the third rising edge after the release.

Top module: `serial_disp_store`

## Requirements
- R1: While `rst_n` is low, all four registers are zero. The display reads 0x00 for every select without waiting for a clock edge.
- R2: On a rising edge with `shift_en` high, the register at index `wr_addr` (0 to 3) becomes `{ser_bit, old[7:1]}`.
- R3: On that edge, the registers whose index differs from `wr_addr` keep their values.
- R4: On a rising edge with `shift_en` low, no register changes, whatever the values of `wr_addr` and `ser_bit`.
- R5: Eight consecutive strobed edges on one address, sending bits b0 first to b7 last, leave that register equal to the byte b7..b0.
- R6: `disp_data` equals the register at index `disp_sel` (0 to 3). A change of `disp_sel` shows on the output before the next clock edge.
- R7: If `wr_addr` changes partway through a byte, each register keeps the partial bits it has received, and later shifts continue from that state.
- R8: After `rst_n` rises, the first two rising edges perform no shift even when the strobe is high. The third edge is the first to shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a two-stage synchroniser |
| wr_addr | input | 2 | Index of the register that the strobe shifts |
| shift_en | input | 1 | Shift strobe for the addressed register |
| ser_bit | input | 1 | Serial data bit that enters the MSB of the addressed register |
| disp_sel | input | 2 | Index of the register shown on the display port |
| disp_data | output | 8 | Value of the selected register |

## Verification
The case that is hardest to reach from the ports is a byte interrupted by a change of address. Two registers then hold partial values at the same time, and the first one later has to resume from its half-filled state. The stimulus starts from a cleared store. It shifts four ones into register 0, moves to register 1 for three ones, returns to register 0 with zeros, and then reads both registers through the display select. The edges just after reset release are also hard to observe. The stimulus holds the strobe high across the release and checks that exactly one bit, the one from the third edge, has entered the register.

// File: rtl/dispstore_pkg.sv
package dispstore_pkg;

  localparam int DEF_DATA_W   = 8;
  localparam int DEF_NUM_REGS = 4;
  localparam int DEF_SYNC_LEN = 2;

  typedef enum logic {
    LANE_HOLD  = 1'b0,
    LANE_SHIFT = 1'b1
  } lane_op_e;

endpackage

// File: rtl/dispstore_rst_sync.sv
module dispstore_rst_sync #(
  parameter int SYNC_LEN = dispstore_pkg::DEF_SYNC_LEN
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [SYNC_LEN-1:0] stage_q;
  logic [SYNC_LEN-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[SYNC_LEN-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[SYNC_LEN-1];

endmodule

// File: rtl/dispstore_addr_dec.sv
module dispstore_addr_dec #(
  parameter int NUM_REGS = dispstore_pkg::DEF_NUM_REGS,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  output logic [NUM_REGS-1:0] lane_en
);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_dec
    assign lane_en[gi] = strobe && (addr == ADDR_W'(gi));
  end

  // R3: at most one lane is enabled in any cycle
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_en));

endmodule

// File: rtl/dispstore_lane.sv
module dispstore_lane #(
  parameter int DATA_W = dispstore_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              ser_bit,
  output logic [DATA_W-1:0] lane_q
);

  import dispstore_pkg::*;

  lane_op_e          op;
  logic [DATA_W-1:0] lane_d;

  always_comb begin
    op = shift_en ? LANE_SHIFT : LANE_HOLD;
    case (op)
      LANE_SHIFT: lane_d = {ser_bit, lane_q[DATA_W-1:1]};
      default:    lane_d = lane_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else if (shift_en) begin
      lane_q <= lane_d;
    end
  end

  // R2: a strobed edge moves the lane right and brings the serial bit into the MSB
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (lane_q == {$past(ser_bit), $past(lane_q[DATA_W-1:1])}));

  // R3: a lane without its enable keeps its value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(lane_q));

endmodule

// File: rtl/dispstore_out_mux.sv
module dispstore_out_mux #(
  parameter int DATA_W   = dispstore_pkg::DEF_DATA_W,
  parameter int NUM_REGS = dispstore_pkg::DEF_NUM_REGS,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] lanes,
  input  logic [ADDR_W-1:0]               sel,
  output logic [DATA_W-1:0]               out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel == ADDR_W'(i)) begin
        out = lanes[i];
      end
    end
  end

endmodule

// File: rtl/serial_disp_store.sv
module serial_disp_store #(
  parameter int DATA_W   = dispstore_pkg::DEF_DATA_W,
  parameter int NUM_REGS = dispstore_pkg::DEF_NUM_REGS,
  parameter int SYNC_LEN = dispstore_pkg::DEF_SYNC_LEN,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              shift_en,
  input  logic              ser_bit,
  input  logic [ADDR_W-1:0] disp_sel,
  output logic [DATA_W-1:0] disp_data
);

  logic                           rst_sync_n;
  logic [NUM_REGS-1:0]            lane_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] lane_q;

  dispstore_rst_sync #(.SYNC_LEN(SYNC_LEN)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dispstore_addr_dec #(.NUM_REGS(NUM_REGS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (wr_addr),
    .strobe  (shift_en),
    .lane_en (lane_en)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_lane
    dispstore_lane #(.DATA_W(DATA_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .shift_en (lane_en[gi]),
      .ser_bit  (ser_bit),
      .lane_q   (lane_q[gi])
    );
  end

  dispstore_out_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_mux (
    .lanes (lane_q),
    .sel   (disp_sel),
    .out   (disp_data)
  );

  // R4: with the strobe low the whole store is frozen
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_en |=> $stable(lane_q));

endmodule

// File: tb/test_serial_disp_store.sv
module test_serial_disp_store;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] wr_addr;
  logic       shift_en;
  logic       ser_bit;
  logic [1:0] disp_sel;
  logic [7:0] disp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_disp_store i_serial_disp_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_addr   (wr_addr),
    .shift_en  (shift_en),
    .ser_bit   (ser_bit),
    .disp_sel  (disp_sel),
    .disp_data (disp_data)
  );

  // {addr[1:0], value[7:0], sel[1:0], expected[7:0]}
  localparam logic [19:0] VECS [8] = '{
    {2'd0, 8'hA5, 2'd0, 8'hA5},
    {2'd1, 8'h3C, 2'd1, 8'h3C},
    {2'd2, 8'hFF, 2'd2, 8'hFF},
    {2'd3, 8'h01, 2'd3, 8'h01},
    {2'd2, 8'h5A, 2'd0, 8'hA5},
    {2'd1, 8'h80, 2'd1, 8'h80},
    {2'd3, 8'h7E, 2'd2, 8'h5A},
    {2'd0, 8'h00, 2'd3, 8'h7E}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_one(input logic [1:0] a, input logic b);
    @(negedge clk);
    wr_addr  = a;
    shift_en = 1'b1;
    ser_bit  = b;
    @(posedge clk);
    #1;
    shift_en = 1'b0;
  endtask

  task automatic send_byte(input logic [1:0] a, input logic [7:0] v);
    for (int i = 0; i < 8; i++) shift_one(a, v[i]);
  endtask

  task automatic look(input logic [1:0] s, input string req, input logic [7:0] exp);
    @(negedge clk);
    disp_sel = s;
    #1;
    check(req, disp_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    wr_addr  = 2'd0;
    shift_en = 1'b0;
    ser_bit  = 1'b0;
    disp_sel = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 4; s++) look(2'(s), "R1 reset state", 8'h00);

    // R5/R3/R6: table of byte writes
    for (int v = 0; v < 8; v++) begin
      send_byte(VECS[v][19:18], VECS[v][17:10]);
      look(VECS[v][9:8], "R5 table byte", VECS[v][7:0]);
    end
    look(2'd0, "R3 final reg0", 8'h00);
    look(2'd1, "R3 final reg1", 8'h80);
    look(2'd2, "R3 final reg2", 8'h5A);
    look(2'd3, "R3 final reg3", 8'h7E);

    // R4: strobe low, address and data toggling
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_addr  = 2'(i);
      ser_bit  = i[0];
      shift_en = 1'b0;
    end
    look(2'd1, "R4 idle reg1", 8'h80);
    look(2'd2, "R4 idle reg2", 8'h5A);
    look(2'd3, "R4 idle reg3", 8'h7E);

    // R6: select change shows without a clock edge
    @(negedge clk);
    disp_sel = 2'd3;
    #1 check("R6 same cycle sel3", disp_data, 8'h7E);
    disp_sel = 2'd2;
    #1 check("R6 same cycle sel2", disp_data, 8'h5A);

    // R1: asynchronous clear, seen before the next edge
    @(negedge clk);
    disp_sel = 2'd2;
    rst_n = 1'b0;
    #1 check("R1 async clear", disp_data, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: address change mid-byte
    for (int i = 0; i < 4; i++) shift_one(2'd0, 1'b1);
    for (int i = 0; i < 3; i++) shift_one(2'd1, 1'b1);
    look(2'd0, "R7 partial reg0", 8'hF0);
    look(2'd1, "R7 partial reg1", 8'hE0);
    for (int i = 0; i < 4; i++) shift_one(2'd0, 1'b0);
    look(2'd0, "R7 resumed reg0", 8'h0F);
    look(2'd1, "R7 kept reg1", 8'hE0);

    // R2: single shift step
    shift_one(2'd0, 1'b1);
    look(2'd0, "R2 one shift", 8'h87);
    shift_one(2'd1, 1'b0);
    look(2'd1, "R2 shift zero in", 8'h70);

    // R8: release with strobe held high on reg3
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    wr_addr  = 2'd3;
    ser_bit  = 1'b1;
    shift_en = 1'b1;
    rst_n    = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    shift_en = 1'b0;
    look(2'd3, "R8 release edges", 8'h80);
    look(2'd0, "R8 other clear", 8'h00);

    finish_run();
  end

endmodule